// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the programming front end of one eight-input interrupt controller. A host writes and reads bytes through a port with two addresses. The block runs the start-up word sequence that the first command triggers. It turns operation commands into actions: several kinds of end-of-interrupt, rotation control, a one-shot poll, selection of the register to read back, and special mask. It also drives the read data for the port.

The request latch and the in-service register are in the resolver core next to this block. The core supplies its request (`irr_i`) and in-service (`isr_i`) vectors. The decoder sends back the mask, the vector base, the rotation base and the mode flags. It also sends single-cycle clear pulses for in-service and request bits. Every side effect of a write or a poll read is registered on the clock edge that samples the strobe, so each clear pulse is visible for the one cycle after that edge. Priority is rotating: the input at the rotation base ranks highest, and rank falls with increasing index modulo 8.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset, the following are zero: mask, vector base, rotation base, all mode flags, and both clear pulses. The block is in the normal state, so the first write to address 1 loads the mask.
- R2: A write to address 0 with data bit 4 set starts the start-up sequence. It zeroes the mask, the rotation base and special mask, and it selects the request vector for address-0 reads.
- R3: The start-up command stores data bit 0 as the "mode word follows" flag. If that bit is 0, the command also clears auto-EOI and special fully nested mode. If it is 1, both flags keep their values.
- R4: The first address-1 write after the start-up command sets the vector base to data AND 0xF8. The second address-1 write (the cascade word, whose content is ignored) returns the block to the normal state if the flag is 0, or moves it to the mode-word state if the flag is 1.
- R5: In the mode-word state, an address-1 write sets special fully nested mode from data bit 4 and auto-EOI from data bit 1, then returns to the normal state.
- R6: An address-0 write with bit 4 = 0 and bit 3 = 1 is a mode command. Bit 2 = 1 arms the poll. Bit 1 = 1 loads the read select from bit 0 (1 = in-service, 0 = request). Bit 6 = 1 loads special mask from bit 5. A select or special mask whose enable bit is 0 keeps its value.
- R7: An address-0 write with bits 4 and 3 = 0 is an operation command whose code is in bits 7:5. Code 4 sets rotate-on-auto-EOI and code 0 clears it.
- R8: Code 1 (non-specific EOI) clears the in-service bit of highest rotating priority. If `isr_i` is empty, it clears nothing.
- R9: Code 5 does the same as code 1 and also sets the rotation base to (cleared index + 1) mod 8. Code 6 sets the rotation base to (bits 2:0 + 1) mod 8 and clears nothing.
- R10: Code 3 clears the in-service bit given by bits 2:0. Code 7 clears that bit and sets the rotation base to (bits 2:0 + 1) mod 8. Code 2 has no effect.
- R11: In the normal state, an address-1 write loads the mask. When no poll is armed, an address-1 read returns the mask, and an address-0 read returns `isr_i` or `irr_i` as the read select chooses.
- R12: A read while the poll is armed (either address) returns the index of the winning request. That index is the highest-priority unmasked request that outranks every in-service bit. The read pulses both clear outputs at that index. If no request wins, the read returns 7 and clears nothing. Any such read disarms the poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Port address |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| irr_i | input | 8 | Request vector from the core |
| isr_i | input | 8 | In-service vector from the core |
| rdata_o | output | 8 | Read data, valid while `rd_i` is high |
| mask_o | output | 8 | Interrupt mask to the core |
| vec_base_o | output | 8 | Vector base, low three bits zero |
| rot_base_o | output | 3 | Index of the highest-priority input |
| auto_eoi_o | output | 1 | Auto end-of-interrupt enable |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| sfnm_o | output | 1 | Special fully nested mode |
| smask_o | output | 1 | Special mask mode |
| isr_clr_o | output | 8 | One-cycle in-service clear pulse |
| irr_clr_o | output | 8 | One-cycle request clear pulse |

## Verification
A wrong start-up state shows up only later, at the ports. The next address-1 write then lands in the wrong register: the mask, the vector base, or the mode flags. So the reference model has to track the sequence state across writes, not just check single commands. A wrong rotation base has no immediate effect of its own. It appears at the next non-specific EOI or poll, as a clear pulse or poll result at the wrong index. For this reason the tests rotate first and then issue those commands. Clear pulses and register updates are compared in the cycle after the strobe. Read data is compared in the cycle of the strobe, so a missing or extra clear, or a poll that is not disarmed, is caught one cycle after the access that caused it.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_VEC  = 2'd1,
    ST_CAS  = 2'd2,
    ST_MODE = 2'd3
  } init_st_e;

  typedef enum logic [2:0] {
    OP_RAEOI_CLR  = 3'd0,
    OP_NS_EOI     = 3'd1,
    OP_NOP        = 3'd2,
    OP_SP_EOI     = 3'd3,
    OP_RAEOI_SET  = 3'd4,
    OP_ROT_NS_EOI = 3'd5,
    OP_SET_BASE   = 3'd6,
    OP_ROT_SP_EOI = 3'd7
  } ocw_op_e;

  typedef struct packed {
    logic init;
    logic mode;
    logic ocw;
    logic port1;
  } wr_dec_t;
endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
  parameter int N = 8
) (
  input  logic [N-1:0]         vec_i,
  input  logic [$clog2(N)-1:0] base_i,
  output logic                 found_o,
  output logic [$clog2(N)-1:0] idx_o,
  output logic [$clog2(N):0]   rank_o
);
  localparam int IW = $clog2(N);

  logic [N-1:0]  rot;
  logic [IW-1:0] rot_pos [N];

  for (genvar g = 0; g < N; g++) begin : g_rot
    logic [IW:0] sum;
    assign sum        = (IW+1)'(g) + {1'b0, base_i};
    assign rot_pos[g] = (sum >= (IW+1)'(N)) ? IW'(sum - (IW+1)'(N)) : IW'(sum);
    assign rot[g]     = vec_i[rot_pos[g]];
  end

  always_comb begin
    found_o = |rot;
    rank_o  = (IW+1)'(N);
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) begin
        rank_o = (IW+1)'(k);
        idx_o  = rot_pos[k];
      end
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_w_i,
  input  logic              port1_w_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mask_we_o,
  output logic [DATA_W-1:0] vec_base_o,
  output logic              auto_eoi_o,
  output logic              sfnm_o
);
  init_st_e          st_q;
  logic              mode_follows_q;
  logic [DATA_W-1:0] vec_q;
  logic              aeoi_q, sfnm_q;

  assign mask_we_o  = port1_w_i && (st_q == ST_RUN);
  assign vec_base_o = vec_q;
  assign auto_eoi_o = aeoi_q;
  assign sfnm_o     = sfnm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= ST_RUN;
      mode_follows_q <= 1'b0;
      vec_q          <= '0;
      aeoi_q         <= 1'b0;
      sfnm_q         <= 1'b0;
    end else if (init_w_i) begin
      mode_follows_q <= wdata_i[0];
      if (!wdata_i[0]) begin
        aeoi_q <= 1'b0;
        sfnm_q <= 1'b0;
      end
      st_q <= ST_VEC;
    end else if (port1_w_i) begin
      unique case (st_q)
        ST_VEC: begin
          vec_q <= wdata_i & 8'hF8;
          st_q  <= ST_CAS;
        end
        ST_CAS:  st_q <= mode_follows_q ? ST_MODE : ST_RUN;
        ST_MODE: begin
          sfnm_q <= wdata_i[4];
          aeoi_q <= wdata_i[1];
          st_q   <= ST_RUN;
        end
        default: ;
      endcase
    end
  end

  assert_vec_then_cas_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_VEC && port1_w_i && !init_w_i) |=> (st_q == ST_CAS));

  assert_mode_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_MODE && port1_w_i && !init_w_i) |=>
      (st_q == ST_RUN && sfnm_q == $past(wdata_i[4]) && aeoi_q == $past(wdata_i[1])));

  assert_no_flag_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_w_i && !wdata_i[0]) |=> (!aeoi_q && !sfnm_q));
endmodule

// File: rtl/pic_ocw_dec.sv
module pic_ocw_dec
  import pic_cmd_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int IW = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_w_i,
  input  logic               mode_w_i,
  input  logic               ocw_w_i,
  input  logic               mask_we_i,
  input  logic               rd_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               top_found_i,
  input  logic [IW-1:0]      top_idx_i,
  input  logic               poll_found_i,
  input  logic [IW-1:0]      poll_idx_i,
  output logic [NUM_IRQ-1:0] mask_o,
  output logic [IW-1:0]      rot_base_o,
  output logic               rot_aeoi_o,
  output logic               smask_o,
  output logic               rsel_o,
  output logic               poll_o,
  output logic [NUM_IRQ-1:0] isr_clr_o,
  output logic [NUM_IRQ-1:0] irr_clr_o
);
  logic [NUM_IRQ-1:0] mask_q, isr_clr_q, irr_clr_q, isr_clr_d, irr_clr_d;
  logic [IW-1:0]      rot_q, rot_nxt, eoi_idx, low;
  logic               raeoi_q, smask_q, rsel_q, poll_q;
  logic               eoi_hit, rot_we, poll_take;
  ocw_op_e            op;

  assign op  = ocw_op_e'(wdata_i[7:5]);
  assign low = wdata_i[IW-1:0];
  assign poll_take = rd_i && poll_q;

  always_comb begin
    eoi_hit = 1'b0;
    eoi_idx = '0;
    rot_we  = 1'b0;
    rot_nxt = '0;
    if (ocw_w_i) begin
      unique case (op)
        OP_NS_EOI: begin
          eoi_hit = top_found_i;
          eoi_idx = top_idx_i;
        end
        OP_ROT_NS_EOI: begin
          eoi_hit = top_found_i;
          eoi_idx = top_idx_i;
          rot_we  = top_found_i;
          rot_nxt = top_idx_i + 1'b1;
        end
        OP_SP_EOI: begin
          eoi_hit = 1'b1;
          eoi_idx = low;
        end
        OP_ROT_SP_EOI: begin
          eoi_hit = 1'b1;
          eoi_idx = low;
          rot_we  = 1'b1;
          rot_nxt = low + 1'b1;
        end
        OP_SET_BASE: begin
          rot_we  = 1'b1;
          rot_nxt = low + 1'b1;
        end
        default: ;
      endcase
    end
    isr_clr_d = '0;
    irr_clr_d = '0;
    if (eoi_hit) isr_clr_d[eoi_idx] = 1'b1;
    if (poll_take && poll_found_i) begin
      isr_clr_d[poll_idx_i] = 1'b1;
      irr_clr_d[poll_idx_i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '0;
      rot_q     <= '0;
      raeoi_q   <= 1'b0;
      smask_q   <= 1'b0;
      rsel_q    <= 1'b0;
      poll_q    <= 1'b0;
      isr_clr_q <= '0;
      irr_clr_q <= '0;
    end else begin
      isr_clr_q <= isr_clr_d;
      irr_clr_q <= irr_clr_d;
      if (poll_take) poll_q <= 1'b0;
      if (init_w_i) begin
        mask_q  <= '0;
        rot_q   <= '0;
        smask_q <= 1'b0;
        rsel_q  <= 1'b0;
      end
      if (mode_w_i) begin
        if (wdata_i[2]) poll_q  <= 1'b1;
        if (wdata_i[1]) rsel_q  <= wdata_i[0];
        if (wdata_i[6]) smask_q <= wdata_i[5];
      end
      if (rot_we) rot_q <= rot_nxt;
      if (ocw_w_i && op == OP_RAEOI_CLR) raeoi_q <= 1'b0;
      if (ocw_w_i && op == OP_RAEOI_SET) raeoi_q <= 1'b1;
      if (mask_we_i) mask_q <= wdata_i[NUM_IRQ-1:0];
    end
  end

  assign mask_o     = mask_q;
  assign rot_base_o = rot_q;
  assign rot_aeoi_o = raeoi_q;
  assign smask_o    = smask_q;
  assign rsel_o     = rsel_q;
  assign poll_o     = poll_q;
  assign isr_clr_o  = isr_clr_q;
  assign irr_clr_o  = irr_clr_q;

  assert_clr_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(isr_clr_q));

  assert_poll_disarm_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && poll_q && !mode_w_i) |=> !poll_q);

  assert_irr_clr_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irr_clr_q != '0) |-> $past(rd_i && poll_q));

  assert_smask_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_w_i && !mode_w_i) |=> $stable(smask_q));
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
  import pic_cmd_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int IW = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_IRQ-1:0] irr_i,
  input  logic [NUM_IRQ-1:0] isr_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NUM_IRQ-1:0] mask_o,
  output logic [DATA_W-1:0]  vec_base_o,
  output logic [IW-1:0]      rot_base_o,
  output logic               auto_eoi_o,
  output logic               rot_aeoi_o,
  output logic               sfnm_o,
  output logic               smask_o,
  output logic [NUM_IRQ-1:0] isr_clr_o,
  output logic [NUM_IRQ-1:0] irr_clr_o
);
  wr_dec_t wd;
  logic    mask_we, rsel, poll_armed;
  logic    req_found, top_found, poll_found;
  logic [IW-1:0] req_idx, top_idx;
  logic [IW:0]   req_rank, top_rank;

  assign wd.init  = wr_i && !addr_i && wdata_i[4];
  assign wd.mode  = wr_i && !addr_i && !wdata_i[4] && wdata_i[3];
  assign wd.ocw   = wr_i && !addr_i && !wdata_i[4] && !wdata_i[3];
  assign wd.port1 = wr_i && addr_i;

  pic_init_seq u_init (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_w_i   (wd.init),
    .port1_w_i  (wd.port1),
    .wdata_i    (wdata_i),
    .mask_we_o  (mask_we),
    .vec_base_o (vec_base_o),
    .auto_eoi_o (auto_eoi_o),
    .sfnm_o     (sfnm_o)
  );

  pic_prio_find #(.N(NUM_IRQ)) u_req_prio (
    .vec_i   (irr_i & ~mask_o),
    .base_i  (rot_base_o),
    .found_o (req_found),
    .idx_o   (req_idx),
    .rank_o  (req_rank)
  );

  pic_prio_find #(.N(NUM_IRQ)) u_isr_prio (
    .vec_i   (isr_i),
    .base_i  (rot_base_o),
    .found_o (top_found),
    .idx_o   (top_idx),
    .rank_o  (top_rank)
  );

  assign poll_found = req_found && (req_rank < top_rank);

  pic_ocw_dec #(.NUM_IRQ(NUM_IRQ)) u_ocw (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .init_w_i     (wd.init),
    .mode_w_i     (wd.mode),
    .ocw_w_i      (wd.ocw),
    .mask_we_i    (mask_we),
    .rd_i         (rd_i),
    .wdata_i      (wdata_i),
    .top_found_i  (top_found),
    .top_idx_i    (top_idx),
    .poll_found_i (poll_found),
    .poll_idx_i   (req_idx),
    .mask_o       (mask_o),
    .rot_base_o   (rot_base_o),
    .rot_aeoi_o   (rot_aeoi_o),
    .smask_o      (smask_o),
    .rsel_o       (rsel),
    .poll_o       (poll_armed),
    .isr_clr_o    (isr_clr_o),
    .irr_clr_o    (irr_clr_o)
  );

  always_comb begin
    if (poll_armed)
      rdata_o = poll_found ? DATA_W'(req_idx) : DATA_W'(NUM_IRQ - 1);
    else if (addr_i)
      rdata_o = DATA_W'(mask_o);
    else
      rdata_o = rsel ? DATA_W'(isr_i) : DATA_W'(irr_i);
  end

  assert_init_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd.init |=> (mask_o == '0 && rot_base_o == '0 && !smask_o));

  assert_eoi_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd.ocw && wdata_i[7:5] == 3'd1 && isr_i == '0) |=> (isr_clr_o == '0));

  assert_nop_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd.ocw && wdata_i[7:5] == 3'd2) |=> (isr_clr_o == '0 && $stable(rot_base_o)));
endmodule

// File: tb/pic_cmd_decoder_tb.sv
module pic_cmd_decoder_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       addr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0, irr_i = '0, isr_i = '0;
  logic [7:0] rdata_o, mask_o, vec_base_o, isr_clr_o, irr_clr_o;
  logic [2:0] rot_base_o;
  logic       auto_eoi_o, rot_aeoi_o, sfnm_o, smask_o;

  int errors = 0;
  int checks = 0;

  always #5 clk_i = ~clk_i;

  pic_cmd_decoder dut_i (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .irr_i, .isr_i,
    .rdata_o, .mask_o, .vec_base_o, .rot_base_o, .auto_eoi_o, .rot_aeoi_o,
    .sfnm_o, .smask_o, .isr_clr_o, .irr_clr_o
  );

  // reference model state
  int         m_st;
  logic       m_flag, m_aeoi, m_sfnm, m_raeoi, m_smask, m_rsel, m_poll;
  logic [7:0] m_mask, m_vec, m_isr_clr, m_irr_clr;
  int         m_rot;

  function automatic int rank_of(logic [7:0] v, int base);
    for (int k = 0; k < 8; k++) if (v[(base + k) % 8]) return k;
    return 8;
  endfunction

  function automatic int winner(logic [7:0] req, logic [7:0] ins, int base);
    int rr = rank_of(req, base);
    int ri = rank_of(ins, base);
    if (rr < 8 && rr < ri) return (base + rr) % 8;
    return -1;
  endfunction

  function automatic logic [7:0] exp_rdata();
    int w;
    if (m_poll) begin
      w = winner(irr_i & ~m_mask, isr_i, m_rot);
      return (w >= 0) ? 8'(w) : 8'd7;
    end
    if (addr_i) return m_mask;
    return m_rsel ? isr_i : irr_i;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_flag = 0; m_aeoi = 0; m_sfnm = 0; m_raeoi = 0; m_smask = 0;
      m_rsel = 0; m_poll = 0; m_mask = 0; m_vec = 0; m_rot = 0;
      m_isr_clr = 0; m_irr_clr = 0;
    end else begin
      int w, t;
      m_isr_clr = 0;
      m_irr_clr = 0;
      if (rd_i && m_poll) begin
        w = winner(irr_i & ~m_mask, isr_i, m_rot);
        if (w >= 0) begin m_isr_clr[w] = 1; m_irr_clr[w] = 1; end
        m_poll = 0;
      end
      if (wr_i && !addr_i) begin
        if (wdata_i[4]) begin
          m_flag = wdata_i[0];
          if (!wdata_i[0]) begin m_aeoi = 0; m_sfnm = 0; end
          m_mask = 0; m_rot = 0; m_smask = 0; m_rsel = 0; m_st = 1;
        end else if (wdata_i[3]) begin
          if (wdata_i[2]) m_poll = 1;
          if (wdata_i[1]) m_rsel = wdata_i[0];
          if (wdata_i[6]) m_smask = wdata_i[5];
        end else begin
          case (wdata_i[7:5])
            0: m_raeoi = 0;
            4: m_raeoi = 1;
            1, 5: begin
              t = rank_of(isr_i, m_rot);
              if (t < 8) begin
                w = (m_rot + t) % 8;
                m_isr_clr[w] = 1;
                if (wdata_i[7]) m_rot = (w + 1) % 8;
              end
            end
            3: m_isr_clr[wdata_i[2:0]] = 1;
            6: m_rot = (int'(wdata_i[2:0]) + 1) % 8;
            7: begin
              m_isr_clr[wdata_i[2:0]] = 1;
              m_rot = (int'(wdata_i[2:0]) + 1) % 8;
            end
            default: ;
          endcase
        end
      end else if (wr_i && addr_i) begin
        case (m_st)
          0: m_mask = wdata_i;
          1: begin m_vec = wdata_i & 8'hF8; m_st = 2; end
          2: m_st = m_flag ? 3 : 0;
          default: begin m_sfnm = wdata_i[4]; m_aeoi = wdata_i[1]; m_st = 0; end
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    chk("R11 mask", mask_o, m_mask);
    chk("R4 vec_base", vec_base_o, m_vec);
    chk("R9 rot_base", {5'd0, rot_base_o}, 8'(m_rot));
    chk("R5 auto_eoi", {7'd0, auto_eoi_o}, {7'd0, m_aeoi});
    chk("R5 sfnm", {7'd0, sfnm_o}, {7'd0, m_sfnm});
    chk("R6 smask", {7'd0, smask_o}, {7'd0, m_smask});
    chk("R7 rot_aeoi", {7'd0, rot_aeoi_o}, {7'd0, m_raeoi});
    chk("R8 isr_clr", isr_clr_o, m_isr_clr);
    chk("R12 irr_clr", irr_clr_o, m_irr_clr);
    chk("R11 rdata", rdata_o, exp_rdata());
  end

  task automatic do_wr(input logic a, input logic [7:0] d);
    @(posedge clk_i); #2;
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); #2;
    wr_i = 1'b0;
  endtask

  task automatic do_rd(input logic a, output logic [7:0] v);
    @(posedge clk_i); #2;
    addr_i = a; rd_i = 1'b1;
    #3 v = rdata_o;
    @(posedge clk_i); #2;
    rd_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;

    // R1 reset state
    do_rd(1'b1, v); chk("R1 mask read", v, 8'h00);
    chk("R1 vec", vec_base_o, 8'h00);
    do_wr(1'b1, 8'h3C); chk("R1 normal state mask load", mask_o, 8'h3C);

    // start-up with mode word
    do_wr(1'b0, 8'h11); chk("R2 mask zeroed", mask_o, 8'h00);
    do_wr(1'b1, 8'h45); chk("R4 vec", vec_base_o, 8'h40);
    do_wr(1'b1, 8'h00);
    do_wr(1'b1, 8'h12); chk("R5 sfnm/aeoi", {6'd0, sfnm_o, auto_eoi_o}, 8'h03);
    do_wr(1'b0, 8'h11); chk("R3 flag keeps aeoi", {6'd0, sfnm_o, auto_eoi_o}, 8'h03);
    do_wr(1'b1, 8'h08); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h12);

    // mask and reads
    do_wr(1'b1, 8'h5A); do_rd(1'b1, v); chk("R11 mask readback", v, 8'h5A);
    irr_i = 8'h81; isr_i = 8'h24;
    do_rd(1'b0, v); chk("R11 irr read", v, 8'h81);
    do_wr(1'b0, 8'h0B); do_rd(1'b0, v); chk("R6 isr select", v, 8'h24);
    do_wr(1'b0, 8'h08); do_rd(1'b0, v); chk("R6 select held", v, 8'h24);
    do_wr(1'b0, 8'h68); chk("R6 smask set", {7'd0, smask_o}, 8'h01);
    do_wr(1'b0, 8'h28); chk("R6 smask held", {7'd0, smask_o}, 8'h01);
    do_wr(1'b0, 8'h48); chk("R6 smask clr", {7'd0, smask_o}, 8'h00);

    // EOI family
    do_wr(1'b0, 8'h20); chk("R8 ns eoi", isr_clr_o, 8'h04);
    isr_i = 8'h00;
    do_wr(1'b0, 8'h20); chk("R8 ns eoi empty", isr_clr_o, 8'h00);
    do_wr(1'b0, 8'hC4); chk("R9 set base", {5'd0, rot_base_o}, 8'h05);
    isr_i = 8'h24;
    do_wr(1'b0, 8'hA0); chk("R9 rot ns eoi clr", isr_clr_o, 8'h20);
    chk("R9 rot ns eoi base", {5'd0, rot_base_o}, 8'h06);
    do_wr(1'b0, 8'h63); chk("R10 specific eoi", isr_clr_o, 8'h08);
    do_wr(1'b0, 8'hE6); chk("R10 rot specific eoi", isr_clr_o, 8'h40);
    chk("R10 rot specific base", {5'd0, rot_base_o}, 8'h07);
    do_wr(1'b0, 8'h40); chk("R10 nop", isr_clr_o, 8'h00);
    chk("R10 nop base", {5'd0, rot_base_o}, 8'h07);
    do_wr(1'b0, 8'h80); chk("R7 raeoi set", {7'd0, rot_aeoi_o}, 8'h01);
    do_wr(1'b0, 8'h00); chk("R7 raeoi clr", {7'd0, rot_aeoi_o}, 8'h00);

    // poll
    do_wr(1'b1, 8'h00);
    irr_i = 8'h30; isr_i = 8'h00;
    do_wr(1'b0, 8'h0C); do_rd(1'b0, v); chk("R12 poll winner", v, 8'h04);
    chk("R12 poll irr clr", irr_clr_o, 8'h10);
    do_rd(1'b1, v); chk("R12 poll disarmed", v, 8'h00);
    irr_i = 8'h00;
    do_wr(1'b0, 8'h0C); do_rd(1'b1, v); chk("R12 poll none", v, 8'h07);
    irr_i = 8'h10; isr_i = 8'h01;
    do_wr(1'b0, 8'h0C); do_rd(1'b0, v); chk("R12 poll blocked", v, 8'h07);

    // start-up without mode word
    do_wr(1'b0, 8'h10);
    chk("R3 no flag clears", {6'd0, sfnm_o, auto_eoi_o}, 8'h00);
    chk("R2 base zeroed", {5'd0, rot_base_o}, 8'h00);
    do_wr(1'b1, 8'h88); do_wr(1'b1, 8'h00);
    do_wr(1'b1, 8'h0F); chk("R4 back to normal", mask_o, 8'h0F);

    // mixed stimulus against the model
    for (int n = 0; n < 600; n++) begin
      int sel;
      @(posedge clk_i); #2;
      sel = $urandom % 4;
      irr_i = 8'($urandom); isr_i = 8'($urandom);
      addr_i = 1'($urandom); wdata_i = 8'($urandom);
      if (sel == 1 && !addr_i && ($urandom % 2 == 0)) wdata_i[4] = 1'b0;
      wr_i = (sel <= 1); rd_i = (sel == 2);
    end
    @(posedge clk_i); #2;
    wr_i = 1'b0; rd_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule